// File: doc/BRIEF.md
# Iterative DES Cipher Engine

This block encrypts or decrypts one 64-bit block under a 64-bit key, following the Data Encryption Standard. It has one Feistel round stage, which is used once per enabled clock. A block therefore takes sixteen enabled cycles. The key holds 56 working bits. The lowest bit of each key byte is a parity bit that the cipher never reads. An optional checker flags any key byte whose ones-count is even.

The host presents a key, a data word and a direction select. While the enable is high, the engine captures the key and data on the first cycle of a block. It then runs the rounds and shows the result together with a strobe that lasts one cycle. If the enable stays high, blocks follow each other with no gap, and fresh key and data are taken every sixteen cycles. Lowering the enable freezes the engine at whatever round it has reached. A synchronous clear throws the current block away, and a new block can begin on the very next cycle.

Top module: `des_iter_engine`

## Requirements
- R1: The active-low reset acts asynchronously. It forces `outValid` and `parErr` low and returns the round counter to the start of a block, so the first enabled cycle after reset captures new key and data. While reset is low, `parErr` stays low whatever the key is.
- R2: With `encSel` = 1, the result equals DES encryption of `dataIn` under `keyIn`. Bit 1 of the standard (the most significant bit) maps to bit index 63 of each bus.
- R3: With `encSel` = 0, the result equals DES decryption of `dataIn` under `keyIn`. The bit mapping is the same as in R2.
- R4: `outValid` goes high in the cycle after the 16th enabled clock edge of a block and stays high for exactly one cycle. It is low in every other cycle. `dataOut` is defined only while `outValid` is high.
- R5: Key and data are sampled on the first enabled cycle of a block only. Changes on `keyIn` and `dataIn` during the rest of that block do not affect its result.
- R6: With `en` held high, the cycle in which `outValid` is high is also the capture cycle of the next block. Blocks repeat with no idle cycle.
- R7: While `en` is low and `clr` is low, the round position and all working state hold for any number of cycles, and `outValid` stays low. Raising `en` resumes from the same round, and the result is the same as with no pause.
- R8: A high `clr` at a clock edge discards the block in progress and clears `outValid`. The aborted block never produces a strobe. The next enabled cycle captures a new block.
- R9: Key bits 0, 8, 16, 24, 32, 40, 48 and 56 (the low bit of each byte) have no effect on the result.
- R10: `parErr` is registered. One edge after sampling, it is high exactly when `parChkEn` was high and at least one key byte had an even number of ones. It is low whenever `parChkEn` was low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for all state |
| rstN | input | 1 | Asynchronous reset, active low |
| en | input | 1 | Advance one round per cycle when high; hold when low |
| clr | input | 1 | Synchronous abort of the block in progress |
| encSel | input | 1 | 1 = encrypt, 0 = decrypt; constant for a whole block |
| parChkEn | input | 1 | Enables the key odd-parity check |
| keyIn | input | 64 | Cipher key, parity bit in the low bit of each byte |
| dataIn | input | 64 | Plaintext or ciphertext block |
| dataOut | output | 64 | Result block, valid with `outValid` |
| outValid | output | 1 | One-cycle strobe marking a finished block |
| parErr | output | 1 | Registered key parity error flag |

## Verification
A fault in the round counter shows at the ports within one block: the strobe arrives early, arrives late or does not arrive at all. A block that was paused or cleared lets the bench measure the strobe against a count of enabled cycles. A wrong table entry, a wrong subkey rotation or a wrong half-swap spreads through the remaining rounds. It corrupts nearly every bit of `dataOut` at the next strobe, which is at most sixteen enabled cycles later. Known-answer vectors in both directions expose such faults, and so does scrambling the inputs right after capture. A parity fault shows on `parErr` one edge after the key changes.

// File: rtl/des_iter_pkg.sv
`timescale 1ns/1ps
package des_iter_pkg;

  localparam int BLOCK_W  = 64;
  localparam int HALF_W   = BLOCK_W / 2;
  localparam int KEY_W    = 64;
  localparam int PC1_W    = 56;
  localparam int CD_W     = PC1_W / 2;
  localparam int SUBKEY_W = 48;
  localparam int ROUNDS   = 16;
  localparam int RND_W    = $clog2(ROUNDS);
  localparam int SBOX_N   = 8;
  localparam int SBOX_IN  = SUBKEY_W / SBOX_N;
  localparam int SBOX_OUT = HALF_W / SBOX_N;

  typedef struct packed {
    logic             load;
    logic             step;
    logic             finish;
    logic             decrypt;
    logic [RND_W-1:0] round;
  } roundCtl_t;

  localparam int SHIFT_TBL [ROUNDS] = '{1,1,2,2,2,2,2,2,1,2,2,2,2,2,2,1};

  localparam int IP_TBL [64] = '{
    58,50,42,34,26,18,10,2, 60,52,44,36,28,20,12,4,
    62,54,46,38,30,22,14,6, 64,56,48,40,32,24,16,8,
    57,49,41,33,25,17,9,1,  59,51,43,35,27,19,11,3,
    61,53,45,37,29,21,13,5, 63,55,47,39,31,23,15,7};

  localparam int FP_TBL [64] = '{
    40,8,48,16,56,24,64,32, 39,7,47,15,55,23,63,31,
    38,6,46,14,54,22,62,30, 37,5,45,13,53,21,61,29,
    36,4,44,12,52,20,60,28, 35,3,43,11,51,19,59,27,
    34,2,42,10,50,18,58,26, 33,1,41,9,49,17,57,25};

  localparam int E_TBL [48] = '{
    32,1,2,3,4,5,     4,5,6,7,8,9,
    8,9,10,11,12,13,  12,13,14,15,16,17,
    16,17,18,19,20,21, 20,21,22,23,24,25,
    24,25,26,27,28,29, 28,29,30,31,32,1};

  localparam int P_TBL [32] = '{
    16,7,20,21,29,12,28,17, 1,15,23,26,5,18,31,10,
    2,8,24,14,32,27,3,9,    19,13,30,6,22,11,4,25};

  localparam int PC1_TBL [56] = '{
    57,49,41,33,25,17,9,  1,58,50,42,34,26,18,
    10,2,59,51,43,35,27,  19,11,3,60,52,44,36,
    63,55,47,39,31,23,15, 7,62,54,46,38,30,22,
    14,6,61,53,45,37,29,  21,13,5,28,20,12,4};

  localparam int PC2_TBL [48] = '{
    14,17,11,24,1,5,   3,28,15,6,21,10,
    23,19,12,4,26,8,   16,7,27,20,13,2,
    41,52,31,37,47,55, 30,40,51,45,33,48,
    44,49,39,56,34,53, 46,42,50,36,29,32};

  localparam int S1_TBL [64] = '{
    14,4,13,1,2,15,11,8,3,10,6,12,5,9,0,7,
    0,15,7,4,14,2,13,1,10,6,12,11,9,5,3,8,
    4,1,14,8,13,6,2,11,15,12,9,7,3,10,5,0,
    15,12,8,2,4,9,1,7,5,11,3,14,10,0,6,13};
  localparam int S2_TBL [64] = '{
    15,1,8,14,6,11,3,4,9,7,2,13,12,0,5,10,
    3,13,4,7,15,2,8,14,12,0,1,10,6,9,11,5,
    0,14,7,11,10,4,13,1,5,8,12,6,9,3,2,15,
    13,8,10,1,3,15,4,2,11,6,7,12,0,5,14,9};
  localparam int S3_TBL [64] = '{
    10,0,9,14,6,3,15,5,1,13,12,7,11,4,2,8,
    13,7,0,9,3,4,6,10,2,8,5,14,12,11,15,1,
    13,6,4,9,8,15,3,0,11,1,2,12,5,10,14,7,
    1,10,13,0,6,9,8,7,4,15,14,3,11,5,2,12};
  localparam int S4_TBL [64] = '{
    7,13,14,3,0,6,9,10,1,2,8,5,11,12,4,15,
    13,8,11,5,6,15,0,3,4,7,2,12,1,10,14,9,
    10,6,9,0,12,11,7,13,15,1,3,14,5,2,8,4,
    3,15,0,6,10,1,13,8,9,4,5,11,12,7,2,14};
  localparam int S5_TBL [64] = '{
    2,12,4,1,7,10,11,6,8,5,3,15,13,0,14,9,
    14,11,2,12,4,7,13,1,5,0,15,10,3,9,8,6,
    4,2,1,11,10,13,7,8,15,9,12,5,6,3,0,14,
    11,8,12,7,1,14,2,13,6,15,0,9,10,4,5,3};
  localparam int S6_TBL [64] = '{
    12,1,10,15,9,2,6,8,0,13,3,4,14,7,5,11,
    10,15,4,2,7,12,9,5,6,1,13,14,0,11,3,8,
    9,14,15,5,2,8,12,3,7,0,4,10,1,13,11,6,
    4,3,2,12,9,5,15,10,11,14,1,7,6,0,8,13};
  localparam int S7_TBL [64] = '{
    4,11,2,14,15,0,8,13,3,12,9,7,5,10,6,1,
    13,0,11,7,4,9,1,10,14,3,5,12,2,15,8,6,
    1,4,11,13,12,3,7,14,10,15,6,8,0,5,9,2,
    6,11,13,8,1,4,10,7,9,5,0,15,14,2,3,12};
  localparam int S8_TBL [64] = '{
    13,2,8,4,6,15,11,1,10,9,3,14,5,0,12,7,
    1,15,13,8,10,3,7,4,12,5,6,11,0,14,9,2,
    7,11,4,1,9,12,14,2,0,6,10,13,15,3,5,8,
    2,1,14,7,4,10,8,13,15,12,9,0,3,5,6,11};

  // Table entries count bits from 1 at the MSB, so entry n selects vector bit (width - n).
  function automatic logic [BLOCK_W-1:0] ipPerm(input logic [BLOCK_W-1:0] x);
    logic [BLOCK_W-1:0] o;
    for (int k = 0; k < BLOCK_W; k++) o[BLOCK_W-1-k] = x[BLOCK_W-IP_TBL[k]];
    return o;
  endfunction

  function automatic logic [BLOCK_W-1:0] fpPerm(input logic [BLOCK_W-1:0] x);
    logic [BLOCK_W-1:0] o;
    for (int k = 0; k < BLOCK_W; k++) o[BLOCK_W-1-k] = x[BLOCK_W-FP_TBL[k]];
    return o;
  endfunction

  function automatic logic [SUBKEY_W-1:0] ePerm(input logic [HALF_W-1:0] x);
    logic [SUBKEY_W-1:0] o;
    for (int k = 0; k < SUBKEY_W; k++) o[SUBKEY_W-1-k] = x[HALF_W-E_TBL[k]];
    return o;
  endfunction

  function automatic logic [HALF_W-1:0] pPerm(input logic [HALF_W-1:0] x);
    logic [HALF_W-1:0] o;
    for (int k = 0; k < HALF_W; k++) o[HALF_W-1-k] = x[HALF_W-P_TBL[k]];
    return o;
  endfunction

  function automatic logic [PC1_W-1:0] pc1Perm(input logic [KEY_W-1:0] x);
    logic [PC1_W-1:0] o;
    for (int k = 0; k < PC1_W; k++) o[PC1_W-1-k] = x[KEY_W-PC1_TBL[k]];
    return o;
  endfunction

  function automatic logic [SUBKEY_W-1:0] pc2Perm(input logic [PC1_W-1:0] x);
    logic [SUBKEY_W-1:0] o;
    for (int k = 0; k < SUBKEY_W; k++) o[SUBKEY_W-1-k] = x[PC1_W-PC2_TBL[k]];
    return o;
  endfunction

  // Row comes from the outer two bits, column from the inner four.
  function automatic logic [SBOX_OUT-1:0] sboxLookup(input int box, input logic [SBOX_IN-1:0] six);
    int idx;
    idx = int'({six[5], six[0], six[4:1]});
    case (box)
      0: return SBOX_OUT'(S1_TBL[idx]);
      1: return SBOX_OUT'(S2_TBL[idx]);
      2: return SBOX_OUT'(S3_TBL[idx]);
      3: return SBOX_OUT'(S4_TBL[idx]);
      4: return SBOX_OUT'(S5_TBL[idx]);
      5: return SBOX_OUT'(S6_TBL[idx]);
      6: return SBOX_OUT'(S7_TBL[idx]);
      default: return SBOX_OUT'(S8_TBL[idx]);
    endcase
  endfunction

endpackage

// File: rtl/des_iter_ctrl.sv
`timescale 1ns/1ps
module des_iter_ctrl
  import des_iter_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             en,
  input  logic             clr,
  input  logic             encSel,
  input  logic             parChkEn,
  input  logic [KEY_W-1:0] keyIn,
  output roundCtl_t        ctl,
  output logic             outValid,
  output logic             parErr
);
  localparam int KEY_BYTES = KEY_W / 8;
  localparam logic [RND_W-1:0] LAST_ROUND = RND_W'(ROUNDS - 1);

  logic [RND_W-1:0]     roundCnt;
  logic [KEY_BYTES-1:0] byteOdd;
  logic                 advance;

  assign advance = en && !clr;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)          roundCnt <= '0;
    else if (clr)       roundCnt <= '0;
    else if (en)        roundCnt <= (roundCnt == LAST_ROUND) ? '0 : roundCnt + 1'b1;
  end

  always_comb begin
    ctl.load    = advance && (roundCnt == '0);
    ctl.step    = advance;
    ctl.finish  = advance && (roundCnt == LAST_ROUND);
    ctl.decrypt = !encSel;
    ctl.round   = roundCnt;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) outValid <= 1'b0;
    else       outValid <= ctl.finish;
  end

  for (genvar b = 0; b < KEY_BYTES; b++) begin : g_byteParity
    assign byteOdd[b] = ^keyIn[8*b +: 8];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) parErr <= 1'b0;
    else       parErr <= parChkEn && !(&byteOdd);
  end
endmodule

// File: rtl/des_iter_keysched.sv
`timescale 1ns/1ps
module des_iter_keysched
  import des_iter_pkg::*;
(
  input  logic [CD_W-1:0]     cIn,
  input  logic [CD_W-1:0]     dIn,
  input  logic [RND_W-1:0]    round,
  input  logic                decrypt,
  output logic [CD_W-1:0]     cOut,
  output logic [CD_W-1:0]     dOut,
  output logic [SUBKEY_W-1:0] subKey
);
  logic [1:0] amt;

  function automatic logic [CD_W-1:0] rotLeft(input logic [CD_W-1:0] x, input logic [1:0] n);
    case (n)
      2'd1:    return {x[CD_W-2:0], x[CD_W-1]};
      2'd2:    return {x[CD_W-3:0], x[CD_W-1 -: 2]};
      default: return x;
    endcase
  endfunction

  function automatic logic [CD_W-1:0] rotRight(input logic [CD_W-1:0] x, input logic [1:0] n);
    case (n)
      2'd1:    return {x[0], x[CD_W-1:1]};
      2'd2:    return {x[1:0], x[CD_W-1:2]};
      default: return x;
    endcase
  endfunction

  // Decryption walks the schedule backwards: no shift first, then the forward amounts reversed.
  always_comb begin
    if (!decrypt)          amt = 2'(SHIFT_TBL[int'(round)]);
    else if (round == '0)  amt = 2'd0;
    else                   amt = 2'(SHIFT_TBL[ROUNDS - int'(round)]);
    cOut   = decrypt ? rotRight(cIn, amt) : rotLeft(cIn, amt);
    dOut   = decrypt ? rotRight(dIn, amt) : rotLeft(dIn, amt);
    subKey = pc2Perm({cOut, dOut});
  end
endmodule

// File: rtl/des_iter_feistel.sv
`timescale 1ns/1ps
module des_iter_feistel
  import des_iter_pkg::*;
(
  input  logic [HALF_W-1:0]   rIn,
  input  logic [SUBKEY_W-1:0] subKey,
  output logic [HALF_W-1:0]   fOut
);
  logic [SUBKEY_W-1:0] mixed;
  logic [HALF_W-1:0]   sOut;

  assign mixed = ePerm(rIn) ^ subKey;

  for (genvar j = 0; j < SBOX_N; j++) begin : g_sbox
    assign sOut[HALF_W-1-SBOX_OUT*j -: SBOX_OUT] =
      sboxLookup(j, mixed[SUBKEY_W-1-SBOX_IN*j -: SBOX_IN]);
  end

  assign fOut = pPerm(sOut);
endmodule

// File: rtl/des_iter_datapath.sv
`timescale 1ns/1ps
module des_iter_datapath
  import des_iter_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  roundCtl_t          ctl,
  input  logic [KEY_W-1:0]   keyIn,
  input  logic [BLOCK_W-1:0] dataIn,
  output logic [BLOCK_W-1:0] dataOut
);
  logic [HALF_W-1:0]   lReg, rReg, srcL, srcR, fOut, newL, newR;
  logic [CD_W-1:0]     cReg, dReg, srcC, srcD, nextC, nextD;
  logic [SUBKEY_W-1:0] subKey;
  logic [BLOCK_W-1:0]  ipOut;
  logic [PC1_W-1:0]    pc1Out;

  // The capture cycle feeds round 1 straight from the inputs.
  always_comb begin
    ipOut  = ipPerm(dataIn);
    pc1Out = pc1Perm(keyIn);
    srcL   = ctl.load ? ipOut[BLOCK_W-1 -: HALF_W] : lReg;
    srcR   = ctl.load ? ipOut[HALF_W-1:0]          : rReg;
    srcC   = ctl.load ? pc1Out[PC1_W-1 -: CD_W]    : cReg;
    srcD   = ctl.load ? pc1Out[CD_W-1:0]           : dReg;
  end

  des_iter_keysched u_keySched (
    .cIn    (srcC),
    .dIn    (srcD),
    .round  (ctl.round),
    .decrypt(ctl.decrypt),
    .cOut   (nextC),
    .dOut   (nextD),
    .subKey (subKey)
  );

  des_iter_feistel u_feistel (
    .rIn   (srcR),
    .subKey(subKey),
    .fOut  (fOut)
  );

  assign newL = srcR;
  assign newR = srcL ^ fOut;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      lReg    <= '0;
      rReg    <= '0;
      cReg    <= '0;
      dReg    <= '0;
      dataOut <= '0;
    end else begin
      if (ctl.step) begin
        lReg <= newL;
        rReg <= newR;
        cReg <= nextC;
        dReg <= nextD;
      end
      if (ctl.finish) dataOut <= fpPerm({newR, newL});
    end
  end
endmodule

// File: rtl/des_iter_engine.sv
`timescale 1ns/1ps
module des_iter_engine
  import des_iter_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  logic               en,
  input  logic               clr,
  input  logic               encSel,
  input  logic               parChkEn,
  input  logic [KEY_W-1:0]   keyIn,
  input  logic [BLOCK_W-1:0] dataIn,
  output logic [BLOCK_W-1:0] dataOut,
  output logic               outValid,
  output logic               parErr
);
  roundCtl_t roundCtl;

  des_iter_ctrl u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .en      (en),
    .clr     (clr),
    .encSel  (encSel),
    .parChkEn(parChkEn),
    .keyIn   (keyIn),
    .ctl     (roundCtl),
    .outValid(outValid),
    .parErr  (parErr)
  );

  des_iter_datapath u_datapath (
    .clk    (clk),
    .rstN   (rstN),
    .ctl    (roundCtl),
    .keyIn  (keyIn),
    .dataIn (dataIn),
    .dataOut(dataOut)
  );
endmodule

// File: rtl/des_iter_checker.sv
`timescale 1ns/1ps
module des_iter_checker
  import des_iter_pkg::*;
(
  input logic             clk,
  input logic             rstN,
  input logic             en,
  input logic             clr,
  input logic             parChkEn,
  input logic             outValid,
  input logic             parErr,
  input logic [RND_W-1:0] roundIdx
);
  // Independent tally of enabled cycles since the block began.
  logic [RND_W:0] enCount;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)      enCount <= '0;
    else if (clr)   enCount <= '0;
    else if (en)    enCount <= (enCount == (RND_W+1)'(ROUNDS - 1)) ? '0 : enCount + 1'b1;
  end

  assert_valid_pulse_R4: assert property (@(posedge clk) disable iff (!rstN)
    outValid |=> !outValid);

  assert_valid_timing_R4: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> ($past(en) && $past(enCount) == (RND_W+1)'(ROUNDS - 1)));

  assert_pause_hold_R7: assert property (@(posedge clk) disable iff (!rstN)
    (!en && !clr) |=> $stable(roundIdx));

  assert_pause_no_valid_R7: assert property (@(posedge clk) disable iff (!rstN)
    !en |=> !outValid);

  assert_clear_abort_R8: assert property (@(posedge clk) disable iff (!rstN)
    clr |=> (!outValid && roundIdx == '0));

  assert_parity_gate_R10: assert property (@(posedge clk) disable iff (!rstN)
    !parChkEn |=> !parErr);
endmodule

bind des_iter_engine des_iter_checker u_checker (
  .clk     (clk),
  .rstN    (rstN),
  .en      (en),
  .clr     (clr),
  .parChkEn(parChkEn),
  .outValid(outValid),
  .parErr  (parErr),
  .roundIdx(roundCtl.round)
);

// File: tb/des_iter_engine_test.sv
`timescale 1ns/1ps
module des_iter_engine_test;
  logic        clk = 1'b0;
  logic        rstN, en, clr, encSel, parChkEn;
  logic [63:0] keyIn, dataIn, dataOut;
  logic        outValid, parErr;
  int          nChecks = 0;
  int          nFails  = 0;

  always #4 clk = ~clk;

  des_iter_engine uut (
    .clk(clk), .rstN(rstN), .en(en), .clr(clr), .encSel(encSel),
    .parChkEn(parChkEn), .keyIn(keyIn), .dataIn(dataIn),
    .dataOut(dataOut), .outValid(outValid), .parErr(parErr)
  );

  // {encSel, key, data in, expected result}
  localparam logic [192:0] VECS [8] = '{
    {1'b1, 64'h133457799BBCDFF1, 64'h0123456789ABCDEF, 64'h85E813540F0AB405},
    {1'b1, 64'h0123456789ABCDEF, 64'h4E6F772069732074, 64'h3FA40E8A984D4815},
    {1'b1, 64'h0101010101010101, 64'h8000000000000000, 64'h95F8A5E5DD31D900},
    {1'b1, 64'h0E329232EA6D0D73, 64'h8787878787878787, 64'h0000000000000000},
    {1'b0, 64'h133457799BBCDFF1, 64'h85E813540F0AB405, 64'h0123456789ABCDEF},
    {1'b0, 64'h0123456789ABCDEF, 64'h3FA40E8A984D4815, 64'h4E6F772069732074},
    {1'b0, 64'h0E329232EA6D0D73, 64'h0000000000000000, 64'h8787878787878787},
    {1'b1, 64'h123556789ABDDEF0, 64'h0123456789ABCDEF, 64'h85E813540F0AB405}
  };
  localparam string VEC_REQ [8] = '{"R2","R2","R2","R2","R3","R3","R3","R9"};

  task automatic check(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic finishRun();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  endtask

  // Called at a falling edge that is a capture cycle; returns at the falling edge of the strobe cycle.
  task automatic runBlock(input logic [192:0] v, input string req);
    encSel = v[192];
    keyIn  = v[191:128];
    dataIn = v[127:64];
    en     = 1'b1;
    for (int i = 0; i < 16; i++) begin
      @(negedge clk);
      if (i == 0) begin
        keyIn  = ~v[191:128];   // R5: later bus changes must not matter
        dataIn = ~v[127:64];
      end
      if (i < 15) check(outValid == 1'b0, "R4", "early strobe", 64'(outValid), 64'd0);
    end
    check(outValid == 1'b1, "R4", "strobe after 16 rounds", 64'(outValid), 64'd1);
    check(dataOut == v[63:0], req, "result", dataOut, v[63:0]);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nFails++;
    $display("FAIL R4 watchdog: actual=timeout expected=completion");
    finishRun();
  end

  initial begin
    rstN = 1'b0; en = 1'b0; clr = 1'b0; encSel = 1'b1;
    parChkEn = 1'b1; keyIn = '0; dataIn = '0;
    repeat (3) @(negedge clk);
    // R1: reset state, even-parity key ignored while reset is low
    check(outValid == 1'b0, "R1", "valid in reset", 64'(outValid), 64'd0);
    check(parErr == 1'b0, "R1", "parity flag in reset", 64'(parErr), 64'd0);
    parChkEn = 1'b0;
    rstN = 1'b1;

    // R2, R3, R9 known answers, R6 back-to-back with en held high
    for (int v = 0; v < 8; v++) runBlock(VECS[v], VEC_REQ[v]);
    en = 1'b0;
    @(negedge clk);
    check(outValid == 1'b0, "R4", "strobe width", 64'(outValid), 64'd0);

    // R7: pause after five rounds, scramble inputs, resume
    encSel = 1'b1; keyIn = VECS[1][191:128]; dataIn = VECS[1][127:64]; en = 1'b1;
    repeat (5) @(negedge clk);
    en = 1'b0; keyIn = '1; dataIn = '0; encSel = 1'b1;
    for (int i = 0; i < 7; i++) begin
      @(negedge clk);
      check(outValid == 1'b0, "R7", "strobe while paused", 64'(outValid), 64'd0);
    end
    en = 1'b1;
    for (int i = 0; i < 11; i++) begin
      @(negedge clk);
      if (i < 10) check(outValid == 1'b0, "R7", "early strobe after resume", 64'(outValid), 64'd0);
    end
    check(outValid == 1'b1, "R7", "strobe after resume", 64'(outValid), 64'd1);
    check(dataOut == VECS[1][63:0], "R7", "paused result", dataOut, VECS[1][63:0]);
    en = 1'b0;
    @(negedge clk);

    // R8: abort after six rounds, then a fresh block
    encSel = 1'b1; keyIn = VECS[2][191:128]; dataIn = VECS[2][127:64]; en = 1'b1;
    repeat (6) @(negedge clk);
    clr = 1'b1;
    @(negedge clk);
    clr = 1'b0;
    check(outValid == 1'b0, "R8", "strobe after clear", 64'(outValid), 64'd0);
    runBlock(VECS[0], "R8");
    en = 1'b0;
    @(negedge clk);

    // R1: asynchronous reset in mid-block restarts the count
    encSel = 1'b1; keyIn = VECS[1][191:128]; dataIn = VECS[1][127:64]; en = 1'b1;
    repeat (4) @(negedge clk);
    #2 rstN = 1'b0;
    #1 check(outValid == 1'b0, "R1", "valid after async reset", 64'(outValid), 64'd0);
    @(negedge clk);
    rstN = 1'b1;
    runBlock(VECS[3], "R1");
    en = 1'b0;

    // R10: parity flag
    parChkEn = 1'b1; keyIn = 64'h133457799BBCDFF0;
    @(negedge clk);
    check(parErr == 1'b1, "R10", "even low byte", 64'(parErr), 64'd1);
    keyIn = 64'h033457799BBCDFF1;
    @(negedge clk);
    check(parErr == 1'b1, "R10", "even high byte", 64'(parErr), 64'd1);
    keyIn = 64'h133457799BBCDFF1;
    @(negedge clk);
    check(parErr == 1'b0, "R10", "all bytes odd", 64'(parErr), 64'd0);
    parChkEn = 1'b0; keyIn = 64'h0000000000000000;
    @(negedge clk);
    check(parErr == 1'b0, "R10", "check disabled", 64'(parErr), 64'd0);

    finishRun();
  end
endmodule